// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Alignment and Error Correction

This block sits behind the analog core of a four-stage pipelined converter. Each clock, the core hands over one raw code per stage. The three front stages each give a 4-bit code that carries one redundant bit. Stage 4 is a plain 4-bit flash code. The codes that belong to one sample arrive on different cycles. Stage 1 leads. Stages 2 and 3 follow one cycle later. Stage 4 follows one cycle after that.

The block works in three steps. First, a per-stage delay line brings all four codes into alignment. Second, it merges the codes with a shift of three bit positions between neighbours, which corresponds to an inter-stage gain of 8. Third, it removes the fixed mid-range bias of the front codes and clamps the result into the 12-bit range. The clamped value is held in an output register in offset-binary form.

An enable input qualifies every capture. While enable is low, the delay line, the fill tracking and the output register all keep their contents, so sample alignment survives gaps in the stream.

Top module: `adc_pipe_corrector`

## Requirements
- R1: At each enabled clock edge, the aligned word combines three codes: `stg1_code` from two enabled edges earlier, `stg2_code` and `stg3_code` from one enabled edge earlier, and `stg4_code` from the current edge.
- R2: The aligned value is S1*512 + S2*64 + S3*8 + S4 - 2336, where S1 to S4 are unsigned 4-bit codes. Front codes with a digit error of one step, absorbed by the next stage through the redundant bit, therefore reproduce the ideal 12-bit word exactly.
- R3: If the aligned value is below 0, the output is 0x000. It never wraps.
- R4: If the aligned value is above 4095, the output is 0xFFF. It never wraps.
- R5: The word for the sample whose stage 1 code is taken at an enabled edge appears on `dout` right after the third enabled edge, counting that edge as the first.
- R6: `dout_valid` is low after reset. It goes high right after the third enabled edge and then stays high until the next reset.
- R7: While `en` is low, `dout` and `dout_valid` keep their values, whatever the stage inputs do. Alignment of the samples in flight is kept across the gap.
- R8: A synchronous active-high `rst` sets `dout` to 0x000, clears `dout_valid`, and clears the delay line.
- R9: The output is offset binary: 0xFFF is the top of the scale, 0x000 is the bottom, and 0x800 is the code just above mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable for all stage inputs |
| stg1_code | input | 4 | Stage 1 code, with redundancy |
| stg2_code | input | 4 | Stage 2 code, with redundancy |
| stg3_code | input | 4 | Stage 3 code, with redundancy |
| stg4_code | input | 4 | Final flash code |
| dout | output | 12 | Corrected offset-binary word |
| dout_valid | output | 1 | High once the pipeline holds a complete sample |

## Verification
The bench uses random 12-bit targets. Each target is split into stage codes, and at every front stage the split picks randomly among the digit choices that the redundancy allows. This way, codes that lean on the redundant bit must decode to the same word as plain codes, and a wrong weight or a wrong offset shows up as a mismatch.

Directed code sets land just past each end of the range and far past it, which separates clamping from wrap-around. Bursts with enable held low and garbage on the stage pins show whether the delay line and the fill count hold without slipping alignment. Targets at mid-scale and at both extremes pin the offset-binary mapping.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

    localparam int NUM_STAGES = 4;
    localparam int CODE_W     = 4;
    localparam int RES_BITS   = 3;
    localparam int OUT_W      = 12;
    localparam int MID_CODE   = 2 ** (CODE_W - 2);
    localparam int OUT_MAX    = (2 ** OUT_W) - 1;

    typedef logic [CODE_W-1:0]                  code_t;
    typedef logic [NUM_STAGES-1:0][CODE_W-1:0]  stage_vec_t;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] word;
    } result_t;

    // Enabled edges a stage code waits before it meets the last stage.
    function automatic int stage_delay(input int idx);
        if (idx == 0)              return NUM_STAGES - 2;
        if (idx == NUM_STAGES - 1) return 0;
        return 1;
    endfunction

    function automatic int stage_shift(input int idx);
        return RES_BITS * (NUM_STAGES - 1 - idx);
    endfunction

    function automatic int bias_total();
        int acc;
        acc = 0;
        for (int i = 0; i < NUM_STAGES - 1; i++)
            acc += MID_CODE << stage_shift(i);
        return acc;
    endfunction

    localparam int OFFSET  = bias_total();
    localparam int LATENCY = stage_delay(0) + 1;

    function automatic logic [OUT_W-1:0] clamp_word(input int v);
        if (v < 0)       return '0;
        if (v > OUT_MAX) return '1;
        return OUT_W'(v);
    endfunction

endpackage

// File: rtl/code_delay.sv
module code_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
        end else if (en) begin
            pipe[0] <= din;
            for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/ec_merge.sv
module ec_merge
    import adc_ec_pkg::*;
(
    input  stage_vec_t       aligned,
    output logic [OUT_W-1:0] word
);

    int acc;

    always_comb begin
        acc = -OFFSET;
        for (int i = 0; i < NUM_STAGES; i++)
            acc += int'(aligned[i]) << stage_shift(i);
        word = clamp_word(acc);
    end

endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
    import adc_ec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] stg1_code,
    input  logic [CODE_W-1:0] stg2_code,
    input  logic [CODE_W-1:0] stg3_code,
    input  logic [CODE_W-1:0] stg4_code,
    output logic [OUT_W-1:0]  dout,
    output logic              dout_valid
);

    localparam int CNT_W = $clog2(LATENCY);

    stage_vec_t       raw;
    stage_vec_t       aligned;
    logic [OUT_W-1:0] merged;
    logic [CNT_W-1:0] fill;
    result_t          out_q;

    assign raw[0] = stg1_code;
    assign raw[1] = stg2_code;
    assign raw[2] = stg3_code;
    assign raw[3] = stg4_code;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        if (stage_delay(g) > 0) begin : g_dly
            code_delay #(
                .W     (CODE_W),
                .DEPTH (stage_delay(g))
            ) u_dly (
                .clk  (clk),
                .rst  (rst),
                .en   (en),
                .din  (raw[g]),
                .dout (aligned[g])
            );
        end else begin : g_direct
            assign aligned[g] = raw[g];
        end
    end

    ec_merge u_merge (
        .aligned (aligned),
        .word    (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            fill  <= '0;
        end else if (en) begin
            out_q.word <= merged;
            if (fill == CNT_W'(LATENCY - 1))
                out_q.valid <= 1'b1;
            else
                fill <= fill + 1'b1;
        end
    end

    assign dout       = out_q.word;
    assign dout_valid = out_q.valid;

endmodule

// File: rtl/adc_pipe_corrector_chk.sv
module adc_pipe_corrector_chk
    import adc_ec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [CODE_W-1:0] stg1_code,
    input logic [CODE_W-1:0] stg2_code,
    input logic [CODE_W-1:0] stg3_code,
    input logic [CODE_W-1:0] stg4_code,
    input logic [OUT_W-1:0]  dout,
    input logic              dout_valid
);

    logic [1:0] en_cnt;
    code_t      h1a, h1b, h2, h3;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            en_cnt <= '0;
            h1a <= '0; h1b <= '0; h2 <= '0; h3 <= '0;
        end else if (en) begin
            if (en_cnt != 2'd3) en_cnt <= en_cnt + 2'd1;
            h1a <= stg1_code;
            h1b <= h1a;
            h2  <= stg2_code;
            h3  <= stg3_code;
        end
    end

    // R8: the first edge after a reset edge sees the cleared output
    always @(posedge clk) begin
        if (!rst && rst_q)
            p_reset_clear_r8: assert (dout == '0 && !dout_valid);
    end

    p_valid_fill_r6: assert property (@(posedge clk) disable iff (rst)
        dout_valid == (en_cnt == 2'd3));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) && $stable(dout_valid)));

    p_clamp_high_r4: assert property (@(posedge clk) disable iff (rst)
        (en && en_cnt >= 2'd2 && h1b == '1 && h2 == '1 && h3 == '1 && stg4_code == '1)
        |=> dout == '1);

    p_clamp_low_r3: assert property (@(posedge clk) disable iff (rst)
        (en && en_cnt >= 2'd2 && h1b == '0 && h2 == '0 && h3 == '0 && stg4_code == '0)
        |=> dout == '0);

endmodule

bind adc_pipe_corrector adc_pipe_corrector_chk chk_i (.*);

// File: tb/adc_pipe_corrector_tb.sv
module adc_pipe_corrector_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [3:0]  stg1_code = '0, stg2_code = '0, stg3_code = '0, stg4_code = '0;
    logic [11:0] dout;
    logic        dout_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int p1_s2 = 0, p1_s3 = 0, p1_s4 = 0, p2_s4 = 0;
    int en_edges = 0;
    int last_dout = 0;
    logic e_s, r_s;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_pipe_corrector dut_i (
        .clk(clk), .rst(rst), .en(en),
        .stg1_code(stg1_code), .stg2_code(stg2_code),
        .stg3_code(stg3_code), .stg4_code(stg4_code),
        .dout(dout), .dout_valid(dout_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Stage codes are staggered: stage 1 now, stages 2/3 one edge later, stage 4 two edges later.
    task automatic push_sample(input int c1, input int c2, input int c3, input int c4, input int expv);
        @(negedge clk);
        en        = 1'b1;
        stg1_code = 4'(c1);
        stg2_code = 4'(p1_s2);
        stg3_code = 4'(p1_s3);
        stg4_code = 4'(p2_s4);
        p2_s4 = p1_s4; p1_s4 = c4; p1_s2 = c2; p1_s3 = c3;
        exp_q.push_back(expv);
    endtask

    task automatic pause(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            en = 1'b0;
            stg1_code = 4'($urandom); stg2_code = 4'($urandom);
            stg3_code = 4'($urandom); stg4_code = 4'($urandom);
        end
    endtask

    function automatic int fdiv(input int r, input int w);
        return (r >= 0) ? r / w : -((-r + w - 1) / w);
    endfunction

    // Split a target into stage codes, picking a random legal redundant digit at each front stage.
    task automatic split_target(input int t, output int c1, output int c2, output int c3, output int c4);
        int r, w, q, nc, lo, hi, d, sc;
        int cand[3];
        int codes[3];
        r = t;
        for (int i = 0; i < 3; i++) begin
            w = 512 >> (3 * i);
            if (i < 2) begin lo = -4 * (w / 8); hi = 12 * (w / 8) - 1; end
            else begin lo = 0; hi = 15; end
            q = fdiv(r, w);
            nc = 0;
            for (int e = -1; e <= 1; e++) begin
                d = q + e;
                sc = d + 4;
                if (sc >= 0 && sc <= 15 && (r - d * w) >= lo && (r - d * w) <= hi) begin
                    cand[nc] = d;
                    nc++;
                end
            end
            d = cand[$urandom_range(nc - 1, 0)];
            codes[i] = d + 4;
            r = r - d * w;
        end
        c1 = codes[0]; c2 = codes[1]; c3 = codes[2]; c4 = r;
    endtask

    task automatic push_target(input int t);
        int c1, c2, c3, c4;
        split_target(t, c1, c2, c3, c4);
        push_sample(c1, c2, c3, c4, t);
    endtask

    // Monitor / scoreboard: sample just after each edge
    always @(posedge clk) begin
        e_s = en;
        r_s = rst;
        #1;
        if (r_s) begin
            en_edges = 0;
            exp_q.delete();
            last_dout = dout;
        end else begin
            if (e_s && en_edges < 3) en_edges++;
            check("R6 valid", int'(dout_valid), (en_edges >= 3) ? 1 : 0);
            if (e_s && dout_valid) begin
                if (exp_q.size() == 0) check("R1 R5 queue underflow", 1, 0);
                else check("R1 R2 R5 R9 word", int'(dout), exp_q.pop_front());
            end else if (!e_s) begin
                check("R7 hold", int'(dout), last_dout);
            end
            last_dout = dout;
        end
    end

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!finished) begin
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset dout", int'(dout), 0);
        check("R8 reset valid", int'(dout_valid), 0);
        rst = 1'b0;

        // R9 mid and extremes, R2 ideal decode
        push_target(12'h800);
        push_target(0);
        push_target(12'hFFF);
        push_target(12'h7FF);
        // R3 low clamp: all-zero and value -1
        push_sample(0, 0, 0, 0, 0);
        push_sample(4, 4, 3, 7, 0);
        // R4 high clamp: all-ones and value 4096
        push_sample(15, 15, 15, 15, 12'hFFF);
        push_sample(11, 11, 11, 8, 12'hFFF);
        // exact top via raw codes (value 4095)
        push_sample(11, 11, 11, 7, 12'hFFF);
        pause(4);   // R7 gap mid-stream
        for (int n = 0; n < 300; n++) begin
            push_target(int'($urandom_range(4095, 0)));
            if (n % 37 == 5) pause(int'($urandom_range(5, 1)));
        end
        for (int n = 0; n < 3; n++) push_target(int'($urandom_range(4095, 0)));
        pause(2);

        // R8 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset dout", int'(dout), 0);
        check("R8 mid reset valid", int'(dout_valid), 0);
        rst = 1'b0;
        p1_s2 = 0; p1_s3 = 0; p1_s4 = 0; p2_s4 = 0;
        for (int n = 0; n < 20; n++) push_target(int'($urandom_range(4095, 0)));
        pause(3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule